// File: doc/BRIEF.md
# Indexed memory-operand cycle sequencer

This block is the control state machine that walks a processor core through the machine cycles of an instruction whose operand lives in memory. Every instruction begins with an opcode-fetch cycle. If the fetched byte is an index prefix, a second fetch brings in the opcode and a memory read brings in a signed 8-bit displacement. A 5-state internal cycle then adds the sign-extended displacement to the chosen index register. Without a prefix, the operand address is taken straight from a register pair. The operand is then read. For the read-modify-write opcode (increment) the incremented value is written back to the same address.

At every clock state the sequencer drives exactly one bus-request strobe: opcode fetch, memory read, memory write or internal. It also drives an address-select code and the operand address. The fetched bytes arrive on `din`. The only back-pressure is `wait_n`: it is sampled in the second state of each memory cycle. While it is low the sequencer repeats that state, so the cycle grows by one state per low clock and the order of cycles is unchanged. Bytes are taken in the last state of each fetch or read cycle. The internal add cycle ignores `wait_n`. After the final state of an instruction, the next state is always a new opcode fetch.

Top module: `idxseq_top`

## Requirements
- R1: While reset is held, the block sits in the first state of an opcode fetch: `m1`=1, `mem_rd`=0, `mem_wr`=0, `done`=0, `addr_sel`=0.
- R2: In every clock state exactly one of `m1`, `mem_rd`, `mem_wr`, `int_cyc` is high.
- R3: A fetched byte matching 11X11101 (0xDD or 0xFD) is an index prefix. X (bit 5) = 0 selects `idx_x` and X = 1 selects `idx_y`. The next byte is fetched as the opcode, and the byte after that is read as the displacement.
- R4: A non-prefixed opcode other than 0x34 (for example 0xAE, 0xBE or 0x86) runs as fetch(4) then read(3), 7 states in all, with the operand read from `pair_addr`.
- R5: Non-prefixed opcode 0x34 runs as fetch(4), read(4), write(3), 11 states in all. The write goes to `pair_addr` and carries the operand plus one, modulo 256.
- R6: A prefixed opcode other than 0x34 runs as fetch(4), fetch(4), read(3), internal(5), read(3), 19 states in all.
- R7: Prefixed opcode 0x34 runs as fetch(4), fetch(4), read(3), internal(5), read(4), write(3), 23 states in all. It writes the operand plus one.
- R8: For prefixed forms, the operand address is the selected index register plus the displacement sign-extended to 16 bits, modulo 2^16.
- R9: `wait_n` low during the second state of a fetch, read or write cycle repeats that state once per low clock. The cycle sequence is unchanged, and the internal cycle is never stretched.
- R10: `done` is high for exactly the final state of each instruction, and the following state is an opcode fetch.
- R11: `addr_sel` is 0 (program counter) in fetch and displacement-read states, 1 (register pair) or 2 (index plus displacement) in operand read and write states, and 3 (no address) in internal states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one clock state |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Byte from memory, taken in the last state of fetch and read cycles |
| wait_n | input | 1 | Low in the second state of a memory cycle stretches that cycle |
| pair_addr | input | 16 | Register-pair operand address |
| idx_x | input | 16 | Index register selected by prefix 0xDD |
| idx_y | input | 16 | Index register selected by prefix 0xFD |
| m1 | output | 1 | Opcode-fetch cycle |
| mem_rd | output | 1 | Memory-read cycle (displacement or operand) |
| mem_wr | output | 1 | Memory-write cycle |
| int_cyc | output | 1 | Internal cycle (address add) |
| addr_sel | output | 2 | Address source: 0 PC, 1 pair, 2 index+d, 3 none |
| op_addr | output | 16 | Operand address, valid when addr_sel is 1 or 2 |
| wdata | output | 8 | Write-back data (operand plus one) |
| done | output | 1 | Final state of the instruction |

## Verification
Each of the four forms is run back to back, with per-state bus type and address-select strings compared against the expected ones. This separates the 3-state and 4-state read lengths and shows whether the internal cycle is present. Displacements of +5, -1, -128 and +127 are used with index bases near zero and near 0xFFFF, so a wrong sign extension, a missing wraparound or a swapped IX/IY choice gives a different operand address. Wait states are placed in fetch, operand-read and write cycles and show up as longer runs of the same strobe, with the sequence unchanged. Operands 0x7F and 0xFF check the write-back value across a carry and across its wraparound.

// File: rtl/idxseq_pkg.sv
package idxseq_pkg;
  typedef enum logic [2:0] {
    MC_FETCH  = 3'd0,
    MC_FETCH2 = 3'd1,
    MC_DISP   = 3'd2,
    MC_ADD    = 3'd3,
    MC_RD     = 3'd4,
    MC_WR     = 3'd5
  } mcyc_e;

  typedef enum logic [1:0] {
    SEL_PC   = 2'd0,
    SEL_PAIR = 2'd1,
    SEL_EA   = 2'd2,
    SEL_NONE = 2'd3
  } asel_e;

  localparam logic [7:0] PFX_MASK = 8'hDF;
  localparam logic [7:0] PFX_CODE = 8'hDD;
  localparam logic [7:0] OP_RMW   = 8'h34;
  localparam int         PFX_YBIT = 5;
endpackage

// File: rtl/idxseq_tcount.sv
module idxseq_tcount #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] len,
  input  logic          hold,
  output logic [TW-1:0] tcnt,
  output logic          last
);
  assign last = (tcnt == len - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          tcnt <= '0;
    else if (hold)       tcnt <= tcnt;
    else if (last)       tcnt <= '0;
    else                 tcnt <= tcnt + TW'(1);
  end
endmodule

// File: rtl/idxseq_ctrl.sv
module idxseq_ctrl
  import idxseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wait_n,
  input  logic [TW-1:0] tcnt,
  input  logic          last,
  output mcyc_e         cyc,
  output logic [TW-1:0] len,
  output logic          hold,
  output logic          done,
  output logic          pfx,
  output logic          use_iy,
  output logic          ea_ld,
  output logic [DW-1:0] disp,
  output logic [DW-1:0] operand
);
  logic rmw;
  logic cyc_end;
  logic is_pfx;

  assign is_pfx  = ((din & DW'(PFX_MASK)) == DW'(PFX_CODE));
  assign hold    = (cyc != MC_ADD) && (tcnt == TW'(1)) && !wait_n;
  assign cyc_end = last && !hold;
  assign ea_ld   = cyc_end && (cyc == MC_ADD);
  assign done    = cyc_end && ((cyc == MC_WR) || ((cyc == MC_RD) && !rmw));

  always_comb begin
    case (cyc)
      MC_FETCH, MC_FETCH2: len = TW'(4);
      MC_DISP:             len = TW'(3);
      MC_ADD:              len = TW'(5);
      MC_RD:               len = rmw ? TW'(4) : TW'(3);
      default:             len = TW'(3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc     <= MC_FETCH;
      pfx     <= 1'b0;
      use_iy  <= 1'b0;
      rmw     <= 1'b0;
      disp    <= '0;
      operand <= '0;
    end else if (cyc_end) begin
      case (cyc)
        MC_FETCH: begin
          if (is_pfx) begin
            pfx    <= 1'b1;
            use_iy <= din[PFX_YBIT];
            cyc    <= MC_FETCH2;
          end else begin
            pfx    <= 1'b0;
            rmw    <= (din == DW'(OP_RMW));
            cyc    <= MC_RD;
          end
        end
        MC_FETCH2: begin
          rmw <= (din == DW'(OP_RMW));
          cyc <= MC_DISP;
        end
        MC_DISP: begin
          disp <= din;
          cyc  <= MC_ADD;
        end
        MC_ADD: cyc <= MC_RD;
        MC_RD: begin
          operand <= din;
          cyc     <= rmw ? MC_WR : MC_FETCH;
        end
        default: cyc <= MC_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/idxseq_addr.sv
module idxseq_addr #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] ea
);
  localparam int EXT = AW - DW;
  logic [AW-1:0] disp_sx;

  generate
    if (EXT > 0) begin : g_ext
      assign disp_sx = {{EXT{disp[DW-1]}}, disp};
    end else begin : g_noext
      assign disp_sx = disp[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)  ea <= '0;
    else if (ld) ea <= base + disp_sx;
  end
endmodule

// File: rtl/idxseq_top.sv
module idxseq_top
  import idxseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wait_n,
  input  logic [AW-1:0] pair_addr,
  input  logic [AW-1:0] idx_x,
  input  logic [AW-1:0] idx_y,
  output logic          m1,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          int_cyc,
  output logic [1:0]    addr_sel,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] wdata,
  output logic          done
);
  mcyc_e         cyc;
  logic [TW-1:0] len, tcnt;
  logic          last, hold, pfx, use_iy, ea_ld;
  logic [DW-1:0] disp, operand;
  logic [AW-1:0] ea;
  asel_e         sel;

  idxseq_tcount #(.TW(TW)) u_tcnt (
    .clk(clk), .rst_n(rst_n), .len(len), .hold(hold), .tcnt(tcnt), .last(last)
  );

  idxseq_ctrl #(.DW(DW), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .din(din), .wait_n(wait_n), .tcnt(tcnt),
    .last(last), .cyc(cyc), .len(len), .hold(hold), .done(done), .pfx(pfx),
    .use_iy(use_iy), .ea_ld(ea_ld), .disp(disp), .operand(operand)
  );

  idxseq_addr #(.AW(AW), .DW(DW)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld(ea_ld), .base(use_iy ? idx_y : idx_x),
    .disp(disp), .ea(ea)
  );

  always_comb begin
    case (cyc)
      MC_FETCH, MC_FETCH2, MC_DISP: sel = SEL_PC;
      MC_ADD:                       sel = SEL_NONE;
      default:                      sel = pfx ? SEL_EA : SEL_PAIR;
    endcase
  end

  assign m1       = (cyc == MC_FETCH) || (cyc == MC_FETCH2);
  assign mem_rd   = (cyc == MC_DISP) || (cyc == MC_RD);
  assign mem_wr   = (cyc == MC_WR);
  assign int_cyc  = (cyc == MC_ADD);
  assign addr_sel = sel;
  assign op_addr  = pfx ? ea : pair_addr;
  assign wdata    = operand + DW'(1);
endmodule

// File: rtl/idxseq_chk.sv
module idxseq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m1,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          int_cyc,
  input logic [1:0]    addr_sel,
  input logic [AW-1:0] op_addr,
  input logic          done
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({m1, mem_rd, mem_wr, int_cyc}) == 1); // R2
  AST_DONE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> m1); // R10
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_rd)); // R5
  AST_INTERNAL_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    int_cyc |-> addr_sel == 2'd3); // R11
  AST_FETCH_PC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    m1 |-> addr_sel == 2'd0); // R11
  AST_WRITE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> $stable(op_addr)); // R7
  AST_INTERNAL_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_cyc) |-> mem_rd && addr_sel == 2'd2); // R6
endmodule

bind idxseq_top idxseq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m1(m1), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .int_cyc(int_cyc), .addr_sel(addr_sel), .op_addr(op_addr), .done(done)
);

// File: tb/tb_idxseq_top.sv
`timescale 1ns/1ps
module tb_idxseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        wait_n = 1'b1;
  logic [15:0] pair_addr = 16'h0000, idx_x = 16'h0000, idx_y = 16'h0000;
  logic        m1, mem_rd, mem_wr, int_cyc, done;
  logic [1:0]  addr_sel;
  logic [15:0] op_addr;
  logic [7:0]  wdata;

  always #4 clk = ~clk;

  idxseq_top dut (
    .clk(clk), .rst_n(rst_n), .din(din), .wait_n(wait_n), .pair_addr(pair_addr),
    .idx_x(idx_x), .idx_y(idx_y), .m1(m1), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .int_cyc(int_cyc), .addr_sel(addr_sel), .op_addr(op_addr), .wdata(wdata),
    .done(done)
  );

  int nchk = 0, nerr = 0, bad_type = 0;
  bit stop_mon = 1'b0, finished = 1'b0;

  string       q_sig[$], q_sel[$], q_tag[$];
  logic [15:0] q_addr[$];
  bit          q_wr[$];
  logic [7:0]  q_wd[$];

  logic [7:0]  st_din[$];
  bit          st_wt[$];
  string       e_sig, e_sel;

  task automatic chk(input bit ok, input string req, input string what,
                     input string act, input string exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %s expected %s", req, what, act, exp);
    end
  endtask

  task automatic add_cyc(input byte t, input byte s, input int len,
                         input int waits, input logic [7:0] b);
    for (int i = 0; i < len; i++) begin
      if (i == 1) begin
        for (int k = 0; k < waits; k++) begin
          st_din.push_back(b); st_wt.push_back(1'b0);
          e_sig = {e_sig, $sformatf("%c", t)};
          e_sel = {e_sel, $sformatf("%c", s)};
        end
      end
      st_din.push_back(b); st_wt.push_back(1'b1);
      e_sig = {e_sig, $sformatf("%c", t)};
      e_sel = {e_sel, $sformatf("%c", s)};
    end
  endtask

  // driver: builds the expected item, pushes it, then drives per-state inputs
  task automatic run_instr(input string tag, input bit pf, input bit iy,
                           input logic [7:0] op, input logic [7:0] d,
                           input logic [7:0] opnd, input logic [15:0] hl_v,
                           input logic [15:0] x_v, input logic [15:0] y_v,
                           input int w_f, input int w_r, input int w_w);
    bit inc;
    logic [15:0] base, exp_addr;
    inc = (op == 8'h34);
    e_sig = ""; e_sel = "";
    st_din.delete(); st_wt.delete();
    base = iy ? y_v : x_v;
    if (pf) begin
      add_cyc("F", "0", 4, w_f, iy ? 8'hFD : 8'hDD);
      add_cyc("F", "0", 4, 0, op);
      add_cyc("R", "0", 3, 0, d);
      add_cyc("I", "3", 5, 0, 8'h00);
      add_cyc("R", "2", inc ? 4 : 3, w_r, opnd);
      if (inc) add_cyc("W", "2", 3, w_w, 8'h00);
      exp_addr = base + {{8{d[7]}}, d};
    end else begin
      add_cyc("F", "0", 4, w_f, op);
      add_cyc("R", "1", inc ? 4 : 3, w_r, opnd);
      if (inc) add_cyc("W", "1", 3, w_w, 8'h00);
      exp_addr = hl_v;
    end
    q_sig.push_back(e_sig); q_sel.push_back(e_sel); q_tag.push_back(tag);
    q_addr.push_back(exp_addr); q_wr.push_back(inc); q_wd.push_back(opnd + 8'd1);
    pair_addr = hl_v; idx_x = x_v; idx_y = y_v;
    for (int i = 0; i < st_din.size(); i++) begin
      din = st_din[i];
      wait_n = st_wt[i];
      @(posedge clk);
      #2;
    end
    din = 8'h00; wait_n = 1'b1;
  endtask

  // monitor: accumulates one instruction between done strobes and compares
  string       m_sig = "", m_sel = "";
  logic [15:0] m_addr = 16'h0;
  bit          m_got_addr = 1'b0, m_wr = 1'b0;
  logic [7:0]  m_wd = 8'h0;

  always @(negedge clk) begin
    if (rst_n && !stop_mon) begin
      if ($countones({m1, mem_rd, mem_wr, int_cyc}) != 1) bad_type++;
      m_sig = {m_sig, m1 ? "F" : mem_rd ? "R" : mem_wr ? "W" : int_cyc ? "I" : "?"};
      m_sel = {m_sel, $sformatf("%0d", addr_sel)};
      if ((addr_sel == 2'd1 || addr_sel == 2'd2) && !m_got_addr) begin
        m_addr = op_addr; m_got_addr = 1'b1;
      end
      if (mem_wr) begin m_wr = 1'b1; m_wd = wdata; end
      if (done) begin
        if (q_sig.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", m_sig, "none");
        end else begin
          string t, es, el;
          logic [15:0] ea;
          bit ew;
          logic [7:0] ed;
          t = q_tag.pop_front(); es = q_sig.pop_front(); el = q_sel.pop_front();
          ea = q_addr.pop_front(); ew = q_wr.pop_front(); ed = q_wd.pop_front();
          chk(m_sig == es, {t, " R10"}, "cycle sequence", m_sig, es);
          chk(m_sel == el, {t, " R11"}, "address select", m_sel, el);
          chk(m_addr == ea, {t, " R8"}, "operand address",
              $sformatf("%h", m_addr), $sformatf("%h", ea));
          chk(m_wr == ew && (!ew || m_wd == ed), t, "write-back",
              $sformatf("wr=%0d %h", m_wr, m_wd), $sformatf("wr=%0d %h", ew, ed));
        end
        m_sig = ""; m_sel = ""; m_got_addr = 1'b0; m_wr = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m1 == 1'b1, "R1", "m1 in reset", $sformatf("%0d", m1), "1");
    chk(done == 1'b0, "R1", "done in reset", $sformatf("%0d", done), "0");
    chk(addr_sel == 2'd0, "R1", "addr_sel in reset", $sformatf("%0d", addr_sel), "0");
    chk(!mem_rd && !mem_wr, "R1", "rd/wr in reset",
        $sformatf("%0d%0d", mem_rd, mem_wr), "00");
    @(posedge clk); #2;
    rst_n = 1'b1;
    run_instr("R4 xor-pair",      0, 0, 8'hAE, 8'h00, 8'h55, 16'h1234, 16'h0, 16'h0, 0, 0, 0);
    run_instr("R4 R9 cmp-wait",   0, 0, 8'hBE, 8'h00, 8'h11, 16'hBEEF, 16'h0, 16'h0, 0, 2, 0);
    run_instr("R5 inc-pair",      0, 0, 8'h34, 8'h00, 8'h7F, 16'h4000, 16'h0, 16'h0, 0, 0, 0);
    run_instr("R3 R6 xor-ix",     1, 0, 8'hAE, 8'h05, 8'h22, 16'h0, 16'h1000, 16'h3000, 0, 0, 0);
    run_instr("R3 R6 R8 cmp-iy",  1, 1, 8'hBE, 8'hFF, 8'h33, 16'h0, 16'h7000, 16'h2000, 0, 0, 0);
    run_instr("R7 R8 inc-ix-neg", 1, 0, 8'h34, 8'h80, 8'hFF, 16'h0, 16'h0050, 16'h9999, 0, 0, 0);
    run_instr("R7 R9 inc-iy-wait",1, 1, 8'h34, 8'h7F, 8'h0A, 16'h0, 16'h1111, 16'hFFF0, 1, 0, 2);
    run_instr("R4 other-op",      0, 0, 8'h86, 8'h00, 8'h01, 16'h0F0F, 16'h0, 16'h0, 3, 1, 0);
    stop_mon = 1'b1;
    chk(q_sig.size() == 0, "R10", "pending items", $sformatf("%0d", q_sig.size()), "0");
    chk(bad_type == 0, "R2", "one strobe per state", $sformatf("%0d", bad_type), "0");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule